// File: doc/BRIEF.md
# Dual-Mode Host Port Decoder

This block is the slave side of a non-multiplexed parallel host port for a device that carries four identical transceiver register banks and one shared global register bank. The host presents a 12-bit address and a 16-bit data word on separate pins. A strap pin picks the strobe convention. With the strap low, a chip select, a data strobe and a read/write level are used. With the strap high, a chip select, a read strobe and a write strobe are used.

Each access is split into a bank code (address bits 11..8), a register group (bits 7..4) and a register (bits 3..0). Codes 0 to 3 pick one transceiver bank and code 9 picks the global bank. Code 8 is a write to all four transceiver banks at once. The strobes are brought into the internal clock domain through a synchroniser. A write is committed once, on the synchronised leading edge of the write strobe. A ready output stays low until a minimum access time has passed, so that fast hosts are held off. The register banks are modelled here as plain storage.

Top module: `host_port_decoder`

## Requirements
- R1: A write with bank code 0, 1, 2 or 3 stores the data word in that transceiver bank only, at the register selected by address bits 7..0. A later read of the same address returns that word.
- R2: Bank code 9 writes to and reads from the global bank. The global bank is separate from every transceiver bank.
- R3: A write with bank code 8 stores the same word at the same register in all four transceiver banks. The global bank is left unchanged.
- R4: A read with bank code 8 returns zero and sets bcast_rd_err. The flag stays high until reset.
- R5: A write with a bank code other than 0 to 3, 8 or 9 changes no bank. A read with such a code returns zero.
- R6: With intel_mode low, a read is cs_n low, ds_n low and rw high, and a write is cs_n low, ds_n low and rw low. In this mode rd_n and wr_n have no effect.
- R7: With intel_mode high, a read is cs_n low with rd_n low, and a write is cs_n low with wr_n low. In this mode ds_n and rw have no effect.
- R8: Each assertion of a write strobe commits exactly one write, using the data present at the synchronised leading edge. A data change while the strobe is still held is not stored.
- R9: rdata_oe is high only while chip select and the read strobe of the selected mode are both active. rdata is zero whenever rdata_oe is low.
- R10: After a strobe is asserted, ready is low for at least MIN_WAIT clock cycles. It then rises and stays high until the strobe is released. With no access in progress, ready is high.
- R11: After reset, every register in every bank reads zero, bcast_rd_err is low, rdata_oe is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intel_mode | input | 1 | Strobe convention strap: 0 data strobe plus read/write level, 1 separate read and write strobes |
| cs_n | input | 1 | Chip select, active low |
| ds_n | input | 1 | Data strobe, active low (strap low only) |
| rw | input | 1 | Read/write level, 1 for read (strap low only) |
| rd_n | input | 1 | Read strobe, active low (strap high only) |
| wr_n | input | 1 | Write strobe, active low (strap high only) |
| addr | input | ADDR_W (12) | Bank code, group and register address |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read data, zero when not enabled |
| rdata_oe | output | 1 | Output enable for the external data bus driver |
| ready | output | 1 | Low while the host must hold the cycle |
| bcast_rd_err | output | 1 | Sticky flag: a read was attempted with the broadcast code |

## Verification
The hardest case to reach is a write strobe held well past the point where ready rises while the data bus changes underneath it. A design that commits on the strobe level instead of its edge gets caught only in that case. Directed accesses keep the strobe low for extra cycles, change wdata after ready rises, and then read the register back. Strobes of the inactive convention are also toggled, with chip select low, to show they are ignored. Random accesses drawn from every bank code in both strap settings are checked against a model of all five banks. A final sweep confirms that broadcast writes gave four identical banks and left the global bank untouched.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
   localparam int BCAST_CODE  = 8;
   localparam int GLOBAL_CODE = 9;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_XCVR   = 2'd1,
      SEL_BCAST  = 2'd2,
      SEL_GLOBAL = 2'd3
   } bank_sel_e;
endpackage

// File: rtl/hpd_strobe.sv
module hpd_strobe #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic intel_mode,
   input  logic cs_n,
   input  logic ds_n,
   input  logic rw,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_raw,
   output logic wr_raw,
   output logic rd_lvl,
   output logic wr_lvl,
   output logic rd_rise,
   output logic wr_rise
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hpd_strobe: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // Strobe convention picked by the strap
   always_comb begin
      if (intel_mode) begin
         rd_raw = !cs_n && !rd_n;
         wr_raw = !cs_n && !wr_n;
      end else begin
         rd_raw = !cs_n && !ds_n && rw;
         wr_raw = !cs_n && !ds_n && !rw;
      end
   end

   logic [SYNC_STAGES-1:0] rd_chain, wr_chain;
   logic                   rd_prev, wr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_chain <= '0;
         wr_chain <= '0;
         rd_prev  <= 1'b0;
         wr_prev  <= 1'b0;
      end else begin
         rd_chain <= {rd_chain[SYNC_STAGES-2:0], rd_raw};
         wr_chain <= {wr_chain[SYNC_STAGES-2:0], wr_raw};
         rd_prev  <= rd_chain[SYNC_STAGES-1];
         wr_prev  <= wr_chain[SYNC_STAGES-1];
      end
   end

   assign rd_lvl  = rd_chain[SYNC_STAGES-1];
   assign wr_lvl  = wr_chain[SYNC_STAGES-1];
   assign rd_rise = rd_lvl && !rd_prev;
   assign wr_rise = wr_lvl && !wr_prev;

   // R8: a commit needs a write strobe that was present on the pins earlier
   assert_commit_has_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rise |-> $past(wr_chain[0]));
endmodule

// File: rtl/hpd_decode.sv
module hpd_decode import hpd_pkg::*; #(
   parameter int ADDR_W    = 12,
   parameter int BANK_BITS = 4,
   parameter int OFF_W     = 8,
   parameter int NUM_XCVR  = 4,
   localparam int XIDX_W   = $clog2(NUM_XCVR)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr_commit,
   output bank_sel_e            sel,
   output logic [XIDX_W-1:0]    idx,
   output logic [OFF_W-1:0]     off,
   output logic [NUM_XCVR-1:0]  xcvr_we,
   output logic                 glb_we
);
   generate
      if (ADDR_W != BANK_BITS + OFF_W) begin : g_bad_split
         $error("hpd_decode: address split does not add up");
      end
      if (NUM_XCVR < 2 || NUM_XCVR > BCAST_CODE) begin : g_bad_num
         $error("hpd_decode: NUM_XCVR must lie in 2..8");
      end
      if (BANK_BITS < XIDX_W) begin : g_bad_bits
         $error("hpd_decode: bank code too narrow");
      end
   endgenerate

   logic [BANK_BITS-1:0] code;
   assign code = addr[ADDR_W-1 -: BANK_BITS];
   assign off  = addr[OFF_W-1:0];
   assign idx  = code[XIDX_W-1:0];

   always_comb begin
      if (int'(code) < NUM_XCVR)          sel = SEL_XCVR;
      else if (int'(code) == BCAST_CODE)  sel = SEL_BCAST;
      else if (int'(code) == GLOBAL_CODE) sel = SEL_GLOBAL;
      else                                sel = SEL_NONE;
   end

   for (genvar b = 0; b < NUM_XCVR; b++) begin : g_we
      assign xcvr_we[b] = wr_commit &&
                          ((sel == SEL_XCVR && idx == XIDX_W'(b)) || sel == SEL_BCAST);
   end
   assign glb_we = wr_commit && (sel == SEL_GLOBAL);

   // R1: outside broadcast, at most one bank is written
   assert_single_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != SEL_BCAST) |-> $onehot0({xcvr_we, glb_we}));
   // R3: broadcast commit reaches every transceiver bank, never the global one
   assert_bcast_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && sel == SEL_BCAST) |-> (&xcvr_we && !glb_we));
   // R5: unassigned codes write nowhere
   assert_ignore_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (xcvr_we == '0 && !glb_we));
endmodule

// File: rtl/hpd_banks.sv
module hpd_banks import hpd_pkg::*; #(
   parameter int NUM_XCVR = 4,
   parameter int DATA_W   = 16,
   parameter int OFF_W    = 8,
   localparam int DEPTH   = 1 << OFF_W,
   localparam int XIDX_W  = $clog2(NUM_XCVR)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_XCVR-1:0]  xcvr_we,
   input  logic                 glb_we,
   input  logic [OFF_W-1:0]     off,
   input  logic [DATA_W-1:0]    wdata,
   input  bank_sel_e            sel,
   input  logic [XIDX_W-1:0]    idx,
   output logic [DATA_W-1:0]    rd_word
);
   logic [DATA_W-1:0] xword [NUM_XCVR];
   logic [DATA_W-1:0] gword;

   for (genvar b = 0; b < NUM_XCVR; b++) begin : g_xbank
      logic [DATA_W-1:0] mem [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (xcvr_we[b]) begin
            mem[off] <= wdata;
         end
      end
      assign xword[b] = mem[off];

      // R1: a committed word is found at its register on the next cycle
      assert_xcvr_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
         xcvr_we[b] |=> (mem[$past(off)] == $past(wdata)));
   end

   logic [DATA_W-1:0] gmem [DEPTH];
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) gmem[i] <= '0;
      end else if (glb_we) begin
         gmem[off] <= wdata;
      end
   end
   assign gword = gmem[off];

   always_comb begin
      unique case (sel)
         SEL_XCVR:   rd_word = xword[idx];
         SEL_GLOBAL: rd_word = gword;
         default:    rd_word = '0;
      endcase
   end

   // R2: a global write lands in the global bank
   assert_glb_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      glb_we |=> (gmem[$past(off)] == $past(wdata)));
endmodule

// File: rtl/host_port_decoder.sv
module host_port_decoder import hpd_pkg::*; #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 16,
   parameter int BANK_BITS   = 4,
   parameter int GRP_BITS    = 4,
   parameter int REG_BITS    = 4,
   parameter int NUM_XCVR    = 4,
   parameter int MIN_WAIT    = 21,
   parameter int SYNC_STAGES = 2,
   localparam int OFF_W      = GRP_BITS + REG_BITS,
   localparam int XIDX_W     = $clog2(NUM_XCVR),
   localparam int CNT_W      = $clog2(MIN_WAIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              intel_mode,
   input  logic              cs_n,
   input  logic              ds_n,
   input  logic              rw,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              ready,
   output logic              bcast_rd_err
);
   generate
      if (MIN_WAIT < 1) begin : g_bad_wait
         $error("host_port_decoder: MIN_WAIT must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("host_port_decoder: DATA_W must be positive");
      end
   endgenerate

   logic rd_raw, wr_raw, rd_lvl, wr_lvl, rd_rise, wr_rise;

   hpd_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
      .clk(clk), .rst_n(rst_n), .intel_mode(intel_mode),
      .cs_n(cs_n), .ds_n(ds_n), .rw(rw), .rd_n(rd_n), .wr_n(wr_n),
      .rd_raw(rd_raw), .wr_raw(wr_raw), .rd_lvl(rd_lvl), .wr_lvl(wr_lvl),
      .rd_rise(rd_rise), .wr_rise(wr_rise)
   );

   bank_sel_e             sel;
   logic [XIDX_W-1:0]     idx;
   logic [OFF_W-1:0]      off;
   logic [NUM_XCVR-1:0]   xcvr_we;
   logic                  glb_we;

   hpd_decode #(
      .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .OFF_W(OFF_W), .NUM_XCVR(NUM_XCVR)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_commit(wr_rise),
      .sel(sel), .idx(idx), .off(off), .xcvr_we(xcvr_we), .glb_we(glb_we)
   );

   logic [DATA_W-1:0] rd_word;

   hpd_banks #(.NUM_XCVR(NUM_XCVR), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_banks (
      .clk(clk), .rst_n(rst_n), .xcvr_we(xcvr_we), .glb_we(glb_we), .off(off),
      .wdata(wdata), .sel(sel), .idx(idx), .rd_word(rd_word)
   );

   // Wait-state timer: counts synchronised access cycles
   logic             acc_lvl, acc_raw, done_q;
   logic [CNT_W-1:0] wait_cnt;

   assign acc_lvl = rd_lvl || wr_lvl;
   assign acc_raw = rd_raw || wr_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_cnt <= CNT_W'(MIN_WAIT);
         done_q   <= 1'b0;
      end else if (!acc_lvl) begin
         wait_cnt <= CNT_W'(MIN_WAIT);
         done_q   <= 1'b0;
      end else if (wait_cnt == '0) begin
         done_q   <= 1'b1;
      end else begin
         wait_cnt <= wait_cnt - 1'b1;
      end
   end

   assign ready = !acc_raw || done_q;

   // Sticky flag for reads aimed at the broadcast code
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          bcast_rd_err <= 1'b0;
      else if (rd_rise && sel == SEL_BCAST) bcast_rd_err <= 1'b1;
   end

   assign rdata_oe = rd_raw;
   assign rdata    = rdata_oe ? rd_word : '0;

   // R4: a broadcast read raises the flag on the next cycle
   assert_bcast_rd_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && sel == SEL_BCAST) |=> bcast_rd_err);
   // R4: the flag never falls outside reset
   assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_rd_err |=> bcast_rd_err);
   // R10: each new access starts with the timer not yet expired
   assert_wait_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_lvl) |-> (!done_q && wait_cnt == CNT_W'(MIN_WAIT)));
endmodule

// File: tb/tb_host_port_decoder.sv
module tb_host_port_decoder;
   localparam int MIN_WAIT = 21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        intel_mode = 1'b0;
   logic        cs_n = 1'b1, ds_n = 1'b1, rw = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [11:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        rdata_oe, ready, bcast_rd_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   host_port_decoder #(.MIN_WAIT(MIN_WAIT)) dut (
      .clk(clk), .rst_n(rst_n), .intel_mode(intel_mode), .cs_n(cs_n), .ds_n(ds_n),
      .rw(rw), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe), .ready(ready), .bcast_rd_err(bcast_rd_err)
   );

   logic [15:0] mx [4][256];
   logic [15:0] mg [256];
   bit          exp_err = 1'b0;

   task automatic check(input bit ok, input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input logic [11:0] a);
      int c = int'(a[11:8]);
      if (c < 4)  return mx[c][a[7:0]];
      if (c == 9) return mg[a[7:0]];
      return 16'h0000;
   endfunction

   function automatic void model_write(input logic [11:0] a, input logic [15:0] d);
      int c = int'(a[11:8]);
      if (c < 4) mx[c][a[7:0]] = d;
      else if (c == 8) for (int b = 0; b < 4; b++) mx[b][a[7:0]] = d;
      else if (c == 9) mg[a[7:0]] = d;
   endfunction

   task automatic idle_pins();
      cs_n = 1'b1; ds_n = 1'b1; rw = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
   endtask

   // One host cycle; hold adds cycles after ready with wdata changed to alt
   task automatic access(input bit im, input bit is_rd, input logic [11:0] a,
                         input logic [15:0] d, input int hold, input logic [15:0] alt,
                         output logic [15:0] got, output bit oe_seen);
      int low = 0;
      @(negedge clk);
      intel_mode = im; addr = a; wdata = d;
      cs_n = 1'b0;
      if (im) begin
         if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
      end else begin
         rw = is_rd; ds_n = 1'b0;
      end
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (ready) break;
         low++;
      end
      check(ready == 1'b1 && low >= MIN_WAIT, "R10 wait length", 16'(low), 16'(MIN_WAIT));
      got = rdata;
      oe_seen = rdata_oe;
      if (hold > 0) begin
         wdata = alt;
         repeat (hold) @(negedge clk);
      end
      idle_pins();
      @(negedge clk);
      check(rdata_oe == 1'b0 && rdata == 16'h0, "R9 released bus", rdata, 16'h0);
      repeat (5) @(negedge clk);
   endtask

   task automatic do_write(input bit im, input logic [11:0] a, input logic [15:0] d);
      logic [15:0] g;
      bit o;
      access(im, 1'b0, a, d, 0, 16'h0, g, o);
      model_write(a, d);
   endtask

   task automatic do_read_chk(input bit im, input logic [11:0] a, input string req);
      logic [15:0] g, e;
      bit o;
      e = exp_read(a);
      access(im, 1'b1, a, 16'h0, 0, 16'h0, g, o);
      if (a[11:8] == 4'h8) exp_err = 1'b1;
      check(g == e, req, g, e);
      check(o == 1'b1, "R9 oe during read", 16'(o), 16'h1);
      check(bcast_rd_err == exp_err, "R4 error flag", 16'(bcast_rd_err), 16'(exp_err));
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] g;
      bit o;
      void'($urandom(32'd1234));
      for (int b = 0; b < 4; b++) for (int i = 0; i < 256; i++) mx[b][i] = '0;
      for (int i = 0; i < 256; i++) mg[i] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(ready == 1'b1, "R11 ready idle", 16'(ready), 16'h1);
      check(rdata_oe == 1'b0, "R11 oe idle", 16'(rdata_oe), 16'h0);
      check(bcast_rd_err == 1'b0, "R11 flag clear", 16'(bcast_rd_err), 16'h0);
      do_read_chk(1'b0, 12'h2A5, "R11 bank reads zero");
      do_read_chk(1'b1, 12'h9A5, "R11 global reads zero");

      // R1 every transceiver code in both modes
      for (int m = 0; m < 2; m++)
         for (int b = 0; b < 4; b++) begin
            do_write(m[0], {4'(b), 8'h3C}, 16'(16'h1100 * (b + 1) + m));
            for (int r = 0; r < 4; r++) do_read_chk(!m[0], {4'(r), 8'h3C}, "R1 bank select");
         end
      // R2 global bank in both modes
      do_write(1'b0, 12'h93C, 16'hBEEF);
      do_read_chk(1'b1, 12'h93C, "R2 global bank");
      do_read_chk(1'b0, 12'h03C, "R2 bank 0 untouched");
      // R3 broadcast in both modes
      do_write(1'b1, 12'h871, 16'hA5A5);
      do_write(1'b0, 12'h93C, 16'h1234);
      do_write(1'b0, 12'h83C, 16'h5A5A);
      for (int b = 0; b < 4; b++) do_read_chk(b[0], {4'(b), 8'h3C}, "R3 broadcast copy");
      do_read_chk(1'b1, 12'h93C, "R3 global kept");
      // R5 unassigned codes
      do_write(1'b0, 12'h53C, 16'hDEAD);
      do_write(1'b1, 12'hF3C, 16'hDEAD);
      do_read_chk(1'b0, 12'h53C, "R5 read zero");
      do_read_chk(1'b1, 12'hA3C, "R5 read zero");
      do_read_chk(1'b0, 12'h13C, "R5 bank unchanged");
      // R8 long strobe with data changing
      access(1'b1, 1'b0, 12'h2E0, 16'h7777, 12, 16'h8888, g, o);
      model_write(12'h2E0, 16'h7777);
      do_read_chk(1'b0, 12'h2E0, "R8 single commit intel");
      access(1'b0, 1'b0, 12'h9E0, 16'h4444, 12, 16'h9999, g, o);
      model_write(12'h9E0, 16'h4444);
      do_read_chk(1'b1, 12'h9E0, "R8 single commit motorola");
      // R6 intel strobes ignored in motorola mode
      @(negedge clk);
      intel_mode = 1'b0; addr = 12'h2E0; wdata = 16'h0BAD;
      cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
      repeat (10) @(negedge clk);
      check(rdata_oe == 1'b0 && ready == 1'b1, "R6 no access seen", 16'(rdata_oe), 16'h0);
      idle_pins();
      repeat (6) @(negedge clk);
      do_read_chk(1'b0, 12'h2E0, "R6 intel pins ignored");
      // R7 motorola strobes ignored in intel mode
      @(negedge clk);
      intel_mode = 1'b1; addr = 12'h2E0; wdata = 16'h0BAD;
      cs_n = 1'b0; ds_n = 1'b0; rw = 1'b0;
      repeat (10) @(negedge clk);
      check(rdata_oe == 1'b0 && ready == 1'b1, "R7 no access seen", 16'(rdata_oe), 16'h0);
      rw = 1'b1;
      @(negedge clk);
      check(rdata_oe == 1'b0, "R7 ds read ignored", 16'(rdata_oe), 16'h0);
      idle_pins();
      repeat (6) @(negedge clk);
      do_read_chk(1'b1, 12'h2E0, "R7 motorola pins ignored");
      // R9 no output without chip select
      @(negedge clk);
      intel_mode = 1'b0; ds_n = 1'b0; rw = 1'b1; addr = 12'h2E0;
      @(negedge clk);
      check(rdata_oe == 1'b0 && rdata == 16'h0, "R9 no chip select", rdata, 16'h0);
      idle_pins();
      repeat (6) @(negedge clk);
      // R4 broadcast read
      do_read_chk(1'b1, 12'h83C, "R4 broadcast read zero");
      do_read_chk(1'b0, 12'h13C, "R4 flag stays set");

      // Random mix over all codes and both modes
      for (int n = 0; n < 250; n++) begin
         int sel = int'($urandom % 8);
         logic [3:0] code;
         logic [11:0] a;
         case (sel)
            0, 1, 2, 3, 7: code = 4'($urandom % 4);
            4:             code = 4'h8;
            5:             code = 4'h9;
            default:       code = ($urandom % 2) ? 4'(4 + $urandom % 4) : 4'(10 + $urandom % 6);
         endcase
         a = {code, 4'($urandom % 4), 4'($urandom % 16)};
         if ($urandom % 2) do_write(1'($urandom), a, 16'($urandom));
         else              do_read_chk(1'($urandom), a, "R1 R2 R5 random read");
      end

      // Final sweep: broadcast addresses left banks consistent
      for (int i = 0; i < 4; i++) begin
         logic [11:0] a = {4'h0, 8'(8'h30 + i)};
         for (int b = 0; b < 4; b++) do_read_chk(1'b0, {4'(b), a[7:0]}, "R3 sweep");
         do_read_chk(1'b1, {4'h9, a[7:0]}, "R2 sweep global");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule